// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block holds a few recent virtual-to-physical page translations so that most memory accesses need no page-table access. A lookup gives a virtual page number and the identifier of the running address space. Every slot is compared with both values at once, and the result appears combinationally in the same cycle. The result is either a hit with the stored physical frame number or a miss. On a miss, the surrounding logic walks the page table itself and then writes the result back through the fill port.

Each slot carries an address-space tag. Translations from several processes can therefore stay resident together, and a context switch does not require a flush. A fill goes into an empty slot while one exists. Once all slots are occupied, the fill replaces the slot used least recently. A single-cycle flush input empties the whole cache.

Top module: `tlb_asid`

## Requirements
- R1: A lookup (`lk_valid`=1) whose page number and tag both match a resident slot drives `lk_hit`=1, `lk_miss`=0 and that slot's frame number on `lk_pfn` in the same cycle.
- R2: A lookup that matches no resident slot drives `lk_miss`=1 and `lk_hit`=0. When `lk_valid`=0, both `lk_hit` and `lk_miss` are 0.
- R3: A slot whose page number matches but whose tag differs does not produce a hit.
- R4: The same page number may be resident under two different tags at once, and each lookup returns the frame that belongs to its own tag.
- R5: While any slot is empty, a fill takes an empty slot, so no resident translation is lost until all 8 slots hold entries.
- R6: A fill into a full cache replaces exactly the least recently used slot, and every other translation stays resident.
- R7: A hit makes its slot the most recently used, and a fill makes the written slot the most recently used.
- R8: `flush`=1 empties every slot in one cycle and returns the recency order to its reset state. A fill in the same cycle is discarded.
- R9: A lookup in the same cycle as a fill sees the contents from before the fill, and the new translation can hit from the next cycle on.
- R10: After reset, no slot is resident and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 8 | Lookup address-space tag |
| lk_hit | output | 1 | Lookup found a translation |
| lk_miss | output | 1 | Lookup found no translation |
| lk_pfn | output | 20 | Frame number on a hit |
| fill_valid | input | 1 | Write a new translation |
| fill_vpn | input | 20 | Page number to write |
| fill_asid | input | 8 | Tag to write |
| fill_pfn | input | 20 | Frame number to write |
| flush | input | 1 | Empty the whole cache |

## Verification
Some properties hold on every cycle, and the assertions check them there. The recency counters always form a permutation. A flush leaves no slot resident. A fill into a cache with free space adds exactly one resident slot, and a full cache stays full after a fill. The slot just hit or just filled becomes the most recent. Which translation actually gets evicted can only be seen through bench scenarios built around a known access history. The same holds for tag separation, for a lookup that coincides with a fill, and for a flush that coincides with a fill.

// File: rtl/tlb_asid.sv
module tlb_asid #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PFN_W-1:0]  lk_pfn,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              flush
);
  localparam int AW = $clog2(ENTRIES);
  typedef logic [ENTRIES-1:0][AW-1:0] age_t;

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  age_t               age_q, age_d;

  logic [ENTRIES-1:0] match;
  logic [AW-1:0]      hit_idx, victim;
  logic               any_match, free_found;

  function automatic age_t touch(age_t a, logic [AW-1:0] idx);
    age_t r = a;
    for (int i = 0; i < ENTRIES; i++)
      if (a[i] < a[idx]) r[i] = a[i] + AW'(1);
    r[idx] = '0;
    return r;
  endfunction

  function automatic age_t reset_ages();
    age_t r;
    for (int i = 0; i < ENTRIES; i++) r[i] = AW'(i);
    return r;
  endfunction

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && vpn_q[g] == lk_vpn && asid_q[g] == lk_asid;
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) hit_idx = AW'(i);
  end

  always_comb begin
    free_found = 1'b0;
    victim     = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (!valid_q[i] && !free_found) begin
        victim     = AW'(i);
        free_found = 1'b1;
      end
    if (!free_found)
      for (int i = 0; i < ENTRIES; i++)
        if (age_q[i] == AW'(ENTRIES - 1)) victim = AW'(i);
  end

  assign any_match = |match;
  assign lk_hit    = lk_valid && any_match;
  assign lk_miss   = lk_valid && !any_match;
  assign lk_pfn    = pfn_q[hit_idx];

  always_comb begin
    age_d = age_q;
    if (lk_hit)     age_d = touch(age_d, hit_idx);
    if (fill_valid) age_d = touch(age_d, victim);
    if (flush)      age_d = reset_ages();
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      age_q   <= reset_ages();
    end else begin
      age_q <= age_d;
      if (flush) valid_q <= '0;
      else if (fill_valid) begin
        valid_q[victim] <= 1'b1;
        vpn_q[victim]   <= fill_vpn;
        asid_q[victim]  <= fill_asid;
        pfn_q[victim]   <= fill_pfn;
      end
    end
  end

  logic [ENTRIES-1:0] age_seen;
  always_comb begin
    age_seen = '0;
    for (int i = 0; i < ENTRIES; i++) age_seen[age_q[i]] = 1'b1;
  end

  AST_AGE_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
    &age_seen); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_q == '0); // R8
  AST_FILL_USES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !flush && !(&valid_q) |=> $countones(valid_q) == $past($countones(valid_q)) + 1); // R5
  AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !flush && (&valid_q) |=> &valid_q); // R6
  AST_FILL_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !flush |=> age_q[$past(victim)] == '0); // R7
  AST_HIT_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit && !fill_valid && !flush |=> age_q[$past(hit_idx)] == '0); // R7
endmodule

// File: tb/tlb_asid_tb_top.sv
module tlb_asid_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, fill_valid = 1'b0, flush = 1'b0;
  logic [19:0] lk_vpn = '0, fill_vpn = '0, fill_pfn = '0;
  logic [7:0]  lk_asid = '0, fill_asid = '0;
  logic        lk_hit, lk_miss;
  logic [19:0] lk_pfn;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  bit          q_hit [$];
  logic [19:0] q_pfn [$];
  string       q_req [$];

  always #5 clk = ~clk;

  tlb_asid dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_pfn(fill_pfn), .flush(flush)
  );

  task automatic cyc(input bit lv, input logic [19:0] lvpn, input logic [7:0] las,
                     input bit fv, input logic [19:0] fvpn, input logic [7:0] fas,
                     input logic [19:0] fpfn, input bit fl,
                     input bit eh, input logic [19:0] ep, input string req);
    @(posedge clk); #1;
    lk_valid = lv; lk_vpn = lvpn; lk_asid = las;
    fill_valid = fv; fill_vpn = fvpn; fill_asid = fas; fill_pfn = fpfn;
    flush = fl;
    if (lv) begin
      q_hit.push_back(eh); q_pfn.push_back(ep); q_req.push_back(req);
    end
  endtask

  task automatic look(input logic [19:0] v, input logic [7:0] a, input bit eh,
                      input logic [19:0] ep, input string req);
    cyc(1, v, a, 0, 0, 0, 0, 0, eh, ep, req);
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] a, input logic [19:0] p);
    cyc(0, 0, 0, 1, v, a, p, 0, 0, 0, "");
  endtask

  always @(negedge clk) begin
    if (rst_n && lk_valid) begin
      checks++;
      if (q_hit.size() == 0) begin
        failures++;
        $display("FAIL scoreboard: unexpected lookup result hit=%0b", lk_hit);
      end else begin
        automatic bit eh = q_hit.pop_front();
        automatic logic [19:0] ep = q_pfn.pop_front();
        automatic string rq = q_req.pop_front();
        if (lk_hit !== eh || lk_miss !== !eh || (eh && lk_pfn !== ep)) begin
          failures++;
          $display("FAIL %s: hit=%0b miss=%0b pfn=%h expected hit=%0b pfn=%h",
                   rq, lk_hit, lk_miss, lk_pfn, eh, ep);
        end
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    look(20'h005, 8'd1, 0, 0, "R10");
    cyc(0, 20'h005, 8'd1, 0, 0, 0, 0, 0, 0, 0, "");
    @(negedge clk);
    checks++;
    if (lk_hit !== 1'b0 || lk_miss !== 1'b0) begin
      failures++;
      $display("FAIL R2: idle hit=%0b miss=%0b expected 0 0", lk_hit, lk_miss);
    end
    for (int i = 0; i < 7; i++) fill(20'h100 + 20'(i), 8'd1, 20'h200 + 20'(i));
    fill(20'h100, 8'd2, 20'hABC);
    for (int i = 0; i < 7; i++) look(20'h100 + 20'(i), 8'd1, 1, 20'h200 + 20'(i), "R5");
    look(20'h103, 8'd1, 1, 20'h203, "R1");
    look(20'h100, 8'd2, 1, 20'hABC, "R4");
    look(20'h100, 8'd1, 1, 20'h200, "R4");
    look(20'h107, 8'd1, 0, 0, "R2");
    look(20'h105, 8'd3, 0, 0, "R3");
    fill(20'h300, 8'd1, 20'h300);
    look(20'h101, 8'd1, 0, 0, "R6");
    look(20'h102, 8'd1, 1, 20'h202, "R6");
    look(20'h300, 8'd1, 1, 20'h300, "R6");
    cyc(1, 20'h400, 8'd1, 1, 20'h400, 8'd1, 20'h401, 0, 0, 0, "R9");
    look(20'h400, 8'd1, 1, 20'h401, "R9");
    look(20'h104, 8'd1, 0, 0, "R6");
    look(20'h105, 8'd1, 1, 20'h205, "R7");
    fill(20'h600, 8'd1, 20'h600);
    look(20'h106, 8'd1, 0, 0, "R7");
    look(20'h105, 8'd1, 1, 20'h205, "R7");
    look(20'h103, 8'd1, 1, 20'h203, "R7");
    cyc(0, 0, 0, 1, 20'h700, 8'd1, 20'h777, 1, 0, 0, "");
    look(20'h103, 8'd1, 0, 0, "R8");
    look(20'h700, 8'd1, 0, 0, "R8");
    look(20'h100, 8'd2, 0, 0, "R8");
    fill(20'h800, 8'd5, 20'h888);
    look(20'h800, 8'd5, 1, 20'h888, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    @(negedge clk);
    checks++;
    if (q_hit.size() != 0) begin
      failures++;
      $display("FAIL R1: %0d lookups left unchecked, expected 0", q_hit.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule